// File: doc/BRIEF.md
# Priority-Partitioned Line Cache

This block is a small set-associative data cache for a storage controller. Its ways are split into two regions. A protected region holds lines for latency-critical requests. A general region holds lines for throughput traffic. Each request carries a word address, a read/write flag, write data and a criticality flag. A hit is answered from the cache and never touches the backend. A miss works as follows. The block picks a victim inside the region that the request's criticality selects. If that victim is dirty, the block first issues a write-back. It then issues a fill request and installs the returned word. Throughput misses can therefore never displace latency-critical lines.

Each set has `WAYS` ways. Ways `0 .. PROT_WAYS-1` form the protected region and the rest form the general region. `PROT_WAYS` must lie between 1 and `WAYS-1`. A line is one data word. The low `$clog2(SETS)` address bits select the set and the remaining bits are the tag.

All data movement uses valid/ready channels: the request, the response, the write-back, the fill request and the fill return. A transfer takes place on a rising edge where both valid and ready are high. Once the block raises a valid, it holds that valid and its payload unchanged until the matching ready arrives. The block accepts one request at a time: `req_ready` is high only while no request is in progress.

Top module: `pcache_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid`, `wb_valid` and `fill_req_valid` are 0. Every line is invalid, so the first access to any address misses.
- R2: A read hit returns the stored word with `rsp_hit`=1, and issues no write-back and no fill request. `rsp_valid` is first seen in the second cycle after the accepting edge.
- R3: A write hit stores `req_wdata` into the line, marks the line dirty and returns the written word. It issues no backend request.
- R4: A miss raises `fill_req_valid` with `fill_req_addr` equal to the request address. When the fill returns, the block installs the line and answers with `rsp_hit`=0. A read miss returns and keeps `fill_data`. A write miss keeps and returns `req_wdata` and marks the line dirty. With backend readies answered at once and a clean victim, `rsp_valid` is first seen in the fourth cycle after the accepting edge.
- R5: A lookup compares the tags of both regions. A throughput request (`req_crit`=0) to an address held in a protected way is a hit.
- R6: A latency-critical miss (`req_crit`=1) allocates only in ways below `PROT_WAYS`. When those ways are all valid, it replaces a protected line, and the lines in the general region stay resident.
- R7: A throughput miss allocates only in ways at or above `PROT_WAYS`, so protected lines stay resident through any number of throughput misses.
- R8: Within a region, the victim is the lowest-numbered invalid way. If the region has no invalid way, the victim is the way named by that region's own round-robin pointer. The pointer advances by one, wrapping inside its region, only after such a replacement. After reset, the protected pointer names way 0 and the general pointer names way `PROT_WAYS`.
- R9: A dirty victim causes `wb_valid` with the victim's address and data, and that transfer completes before `fill_req_valid` rises.
- R10: While any valid is high and its ready is low, that valid and its payload stay unchanged. `req_ready` is 0 from the accepting edge until the response transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Word address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write data |
| req_crit | input | 1 | 1 = latency-critical, 0 = throughput |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_hit | output | 1 | 1 = request hit in the cache |
| rsp_data | output | DATA_W | Line word after the access |
| wb_valid | output | 1 | Write-back of a dirty victim |
| wb_ready | input | 1 | Backend takes the write-back |
| wb_addr | output | ADDR_W | Address of the victim line |
| wb_data | output | DATA_W | Data of the victim line |
| fill_req_valid | output | 1 | Fill request valid |
| fill_req_ready | input | 1 | Backend takes the fill request |
| fill_req_addr | output | ADDR_W | Address to fetch |
| fill_valid | input | 1 | Fill data valid |
| fill_ready | output | 1 | Block waits for fill data |
| fill_data | input | DATA_W | Fetched word |

## Verification
Latency is counted at falling edges after the edge that accepts a request. A hit answers at count 2. A clean miss with backend readies given at once answers at count 4. Each dirty-victim write-back that completes without stall adds one count. The bench raises each ready at a falling edge, in response to a valid it sees there, so every handshake lands on the next rising edge. It compares the measured count with these values in the scenarios where no ready is held back. Where a ready is held back, the bench checks at each held cycle that the valid and its payload have not changed.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_WB,
    ST_FREQ,
    ST_FWAIT,
    ST_RESP
  } pc_state_e;
endpackage

// File: rtl/pc_tag_match.sv
module pc_tag_match #(
  parameter int TAG_W = 10,
  parameter int WAYS  = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] row_tags,
  input  logic [WAYS-1:0]       row_vld,
  input  logic [TAG_W-1:0]      tag,
  output logic [WAYS-1:0]       hit_vec,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  // every way of the set is compared, whatever region it belongs to
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = row_vld[w] && (row_tags[w*TAG_W +: TAG_W] == tag);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    hit = |hit_vec;
  end
endmodule

// File: rtl/pc_victim.sv
module pc_victim #(
  parameter int WAYS      = 4,
  parameter int PROT_WAYS = 1,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  row_vld,
  input  logic             crit,
  input  logic             adv,
  input  logic             adv_crit,
  output logic [WAY_W-1:0] vic_way,
  output logic             vic_by_ptr
);
  localparam logic [WAY_W-1:0] PROT_LAST = WAY_W'(PROT_WAYS - 1);
  localparam logic [WAY_W-1:0] GEN_FIRST = WAY_W'(PROT_WAYS);
  localparam logic [WAY_W-1:0] GEN_LAST  = WAY_W'(WAYS - 1);

  logic [WAY_W-1:0] prot_ptr, gen_ptr;
  logic [WAY_W-1:0] free_way;
  logic             free_found;

  // lowest invalid way inside the chosen region
  always_comb begin
    free_way   = '0;
    free_found = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if ((crit ? (w < PROT_WAYS) : (w >= PROT_WAYS)) && !row_vld[w]) begin
        free_way   = WAY_W'(w);
        free_found = 1'b1;
      end
    end
    vic_by_ptr = !free_found;
    vic_way    = free_found ? free_way : (crit ? prot_ptr : gen_ptr);
  end

  // one round-robin pointer per region, advanced only on replacement
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prot_ptr <= '0;
      gen_ptr  <= GEN_FIRST;
    end else if (adv) begin
      if (adv_crit) prot_ptr <= (prot_ptr == PROT_LAST) ? '0 : prot_ptr + 1'b1;
      else          gen_ptr  <= (gen_ptr == GEN_LAST) ? GEN_FIRST : gen_ptr + 1'b1;
    end
  end

  p_ptr_region_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(prot_ptr) < PROT_WAYS) && (int'(gen_ptr) >= PROT_WAYS));
endmodule

// File: rtl/pcache_top.sv
module pcache_top
  import pc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  parameter int PROT_WAYS = 1   // 1 .. WAYS-1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_crit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              fill_req_valid,
  input  logic              fill_req_ready,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  pc_state_e state;

  // captured request
  logic [ADDR_W-1:0] a_q;
  logic              wr_q, crit_q;
  logic [DATA_W-1:0] wd_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tg;
  assign idx = a_q[IDX_W-1:0];
  assign tg  = a_q[ADDR_W-1:IDX_W];

  // line storage
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [DATA_W-1:0] dat_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q [SETS];
  logic [WAYS-1:0]   dty_q [SETS];

  logic [WAYS*TAG_W-1:0] row_tags;
  always_comb begin
    for (int w = 0; w < WAYS; w++) row_tags[w*TAG_W +: TAG_W] = tag_q[idx][w];
  end

  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;

  pc_tag_match #(.TAG_W(TAG_W), .WAYS(WAYS)) u_match (
    .row_tags(row_tags), .row_vld(vld_q[idx]), .tag(tg),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way)
  );

  logic [WAY_W-1:0] vic_way, vway_q;
  logic             vic_by_ptr, vptr_q;
  logic             install_en, hit_wr_en;
  logic [DATA_W-1:0] line_in;

  assign install_en = (state == ST_FWAIT) && fill_valid;
  assign hit_wr_en  = (state == ST_LOOK) && hit && wr_q;
  assign line_in    = wr_q ? wd_q : fill_data;

  pc_victim #(.WAYS(WAYS), .PROT_WAYS(PROT_WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .row_vld(vld_q[idx]), .crit(crit_q),
    .adv(install_en && vptr_q), .adv_crit(crit_q),
    .vic_way(vic_way), .vic_by_ptr(vic_by_ptr)
  );

  logic [ADDR_W-1:0] wb_addr_q;
  logic [DATA_W-1:0] wb_data_q, rsp_data_q;
  logic              rsp_hit_q;

  // control path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      a_q       <= '0;
      wr_q      <= 1'b0;
      crit_q    <= 1'b0;
      wd_q      <= '0;
      vway_q    <= '0;
      vptr_q    <= 1'b0;
      wb_addr_q <= '0;
      wb_data_q <= '0;
      rsp_data_q <= '0;
      rsp_hit_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          a_q    <= req_addr;
          wr_q   <= req_write;
          wd_q   <= req_wdata;
          crit_q <= req_crit;
          state  <= ST_LOOK;
        end
        ST_LOOK: if (hit) begin
          rsp_hit_q  <= 1'b1;
          rsp_data_q <= wr_q ? wd_q : dat_q[idx][hit_way];
          state      <= ST_RESP;
        end else begin
          vway_q <= vic_way;
          vptr_q <= vic_by_ptr;
          if (vld_q[idx][vic_way] && dty_q[idx][vic_way]) begin
            wb_addr_q <= {tag_q[idx][vic_way], idx};
            wb_data_q <= dat_q[idx][vic_way];
            state     <= ST_WB;
          end else begin
            state <= ST_FREQ;
          end
        end
        ST_WB:    if (wb_ready) state <= ST_FREQ;
        ST_FREQ:  if (fill_req_ready) state <= ST_FWAIT;
        ST_FWAIT: if (fill_valid) begin
          rsp_hit_q  <= 1'b0;
          rsp_data_q <= line_in;
          state      <= ST_RESP;
        end
        ST_RESP:  if (rsp_ready) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // valid and dirty bits
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
      end
    end else begin
      if (hit_wr_en) dty_q[idx][hit_way] <= 1'b1;
      if (install_en) begin
        vld_q[idx][vway_q] <= 1'b1;
        dty_q[idx][vway_q] <= wr_q;
      end
    end
  end

  // tags and data carry no reset
  always_ff @(posedge clk) begin
    if (hit_wr_en) dat_q[idx][hit_way] <= wd_q;
    if (install_en) begin
      tag_q[idx][vway_q] <= tg;
      dat_q[idx][vway_q] <= line_in;
    end
  end

  assign req_ready      = (state == ST_IDLE);
  assign rsp_valid      = (state == ST_RESP);
  assign rsp_hit        = rsp_hit_q;
  assign rsp_data       = rsp_data_q;
  assign wb_valid       = (state == ST_WB);
  assign wb_addr        = wb_addr_q;
  assign wb_data        = wb_data_q;
  assign fill_req_valid = (state == ST_FREQ);
  assign fill_req_addr  = a_q;
  assign fill_ready     = (state == ST_FWAIT);

  p_unique_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOK) |-> $onehot0(hit_vec));
  p_hit_no_backend_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOOK && hit) |=> (!wb_valid && !fill_req_valid && rsp_valid));
  p_crit_in_prot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (install_en && crit_q) |-> (int'(vway_q) < PROT_WAYS));
  p_thr_in_general_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (install_en && !crit_q) |-> (int'(vway_q) >= PROT_WAYS));
  p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
  p_wb_then_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready) |=> fill_req_valid);
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)));
  p_fill_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));
endmodule

// File: tb/sim_pcache_top.sv
module sim_pcache_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_crit = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit, wb_valid, fill_req_valid, fill_ready;
  logic rsp_ready = 0, wb_ready = 0, fill_req_ready = 0, fill_valid = 0;
  logic [DW-1:0] rsp_data, wb_data;
  logic [DW-1:0] fill_data = '0;
  logic [AW-1:0] wb_addr, fill_req_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcache_top #(.ADDR_W(AW), .DATA_W(DW), .SETS(4), .WAYS(4), .PROT_WAYS(1)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_crit(req_crit),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_data(fill_data)
  );

  function automatic logic [DW-1:0] memv(input logic [AW-1:0] a);
    return 32'hC0DE_0000 | 32'(a);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One access with a responsive backend; wdly/rdly hold back wb_ready/rsp_ready.
  task automatic do_acc(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                        input logic crit, input int rdly, input int wdly,
                        output logic hit, output logic [DW-1:0] data, output int lat,
                        output logic saw_wb, output logic [AW-1:0] wba,
                        output logic [DW-1:0] wbd, output logic saw_fill,
                        output logic [AW-1:0] fa, output logic wb_first);
    int n, wcnt, rcnt;
    logic done;
    logic [DW-1:0] rd0;
    @(negedge clk);
    rsp_ready = 0; wb_ready = 0; fill_req_ready = 0; fill_valid = 0;
    chk(req_ready == 1'b1, "R10 idle ready", 32'(req_ready), 1);
    req_addr = a; req_write = wr; req_wdata = wd; req_crit = crit; req_valid = 1;
    hit = 0; data = '0; lat = 0; saw_wb = 0; wba = '0; wbd = '0;
    saw_fill = 0; fa = '0; wb_first = 0; done = 0; n = 0; wcnt = 0; rcnt = 0; rd0 = '0;
    @(posedge clk);
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
      req_valid = 0;
      wb_ready = 0; fill_req_ready = 0; rsp_ready = 0;
      if (n == 1) chk(req_ready == 1'b0, "R10 busy", 32'(req_ready), 0);
      fill_valid = fill_ready;
      fill_data  = memv(fill_req_addr);
      if (wb_valid) begin
        if (wcnt == 0) begin
          wba = wb_addr; wbd = wb_data; saw_wb = 1;
        end else begin
          chk(wb_addr == wba && wb_data == wbd, "R10 wb hold", wb_data, wbd);
        end
        wcnt++;
        wb_ready = (wcnt > wdly);
      end
      if (fill_req_valid) begin
        saw_fill = 1; fa = fill_req_addr; wb_first = saw_wb;
        fill_req_ready = 1;
      end
      if (rsp_valid) begin
        if (rcnt == 0) begin
          lat = n; rd0 = rsp_data;
        end else begin
          chk(rsp_data == rd0, "R10 rsp hold", rsp_data, rd0);
        end
        rcnt++;
        if (rcnt > rdly) begin
          rsp_ready = 1; hit = rsp_hit; data = rsp_data; done = 1;
        end
      end
      @(posedge clk);
    end
  endtask

  // short form for read/write with immediate readies
  logic h, sw, sf, wf;
  logic [DW-1:0] d, wbd;
  logic [AW-1:0] wba, fa;
  int lat;

  task automatic acc(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                     input logic crit);
    do_acc(a, wr, wd, crit, 0, 0, h, d, lat, sw, wba, wbd, sf, fa, wf);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1 && rsp_valid == 0, "R1 ready/rsp", {req_ready, rsp_valid}, 2'b10);
    chk(wb_valid == 0 && fill_req_valid == 0, "R1 backend idle",
        {wb_valid, fill_req_valid}, 0);
  endtask

  task automatic t_miss_then_hit();
    acc(12'h004, 0, 0, 0);
    chk(h == 0, "R1 first access misses", h, 0);
    chk(sf == 1 && fa == 12'h004, "R4 fill addr", fa, 12'h004);
    chk(d == memv(12'h004), "R4 fill data", d, memv(12'h004));
    chk(lat == 4, "R4 miss latency", lat, 4);
    acc(12'h004, 0, 0, 0);
    chk(h == 1 && d == memv(12'h004), "R2 hit data", d, memv(12'h004));
    chk(lat == 2, "R2 hit latency", lat, 2);
    chk(sf == 0 && sw == 0, "R2 no backend", {sf, sw}, 0);
  endtask

  task automatic t_cross_hit();
    acc(12'h008, 0, 0, 1);  // into protected way 0
    chk(h == 0, "R6 crit miss", h, 0);
    acc(12'h008, 0, 0, 0);
    chk(h == 1 && d == memv(12'h008), "R5 thr hits protected line", h, 1);
  endtask

  task automatic t_thr_evict();
    acc(12'h00C, 0, 0, 0);  // way2
    acc(12'h010, 0, 0, 0);  // way3
    acc(12'h014, 0, 0, 0);  // ptr way1 evicts 004
    chk(h == 0, "R7 thr miss", h, 0);
    acc(12'h008, 0, 0, 1);
    chk(h == 1, "R7 protected line survives", h, 1);
    acc(12'h004, 0, 0, 0);  // ptr way2 evicts 00C
    chk(h == 0, "R8 round-robin evicted way1", h, 0);
    acc(12'h010, 0, 0, 0);
    chk(h == 1, "R8 way3 kept", h, 1);
    acc(12'h014, 0, 0, 0);
    chk(h == 1, "R8 way1 refilled", h, 1);
  endtask

  task automatic t_crit_evict();
    acc(12'h018, 0, 0, 1);  // protected full: evicts 008
    chk(h == 0, "R6 crit miss", h, 0);
    acc(12'h014, 0, 0, 0);
    chk(h == 1, "R6 general 014 kept", h, 1);
    acc(12'h004, 0, 0, 0);
    chk(h == 1, "R6 general 004 kept", h, 1);
    acc(12'h010, 0, 0, 0);
    chk(h == 1, "R6 general 010 kept", h, 1);
    acc(12'h018, 0, 0, 1);
    chk(h == 1 && d == memv(12'h018), "R6 new protected line", d, memv(12'h018));
    acc(12'h008, 0, 0, 0);  // ptr way3 evicts 010
    chk(h == 0, "R6 replaced protected line", h, 0);
  endtask

  task automatic t_dirty_wb();
    acc(12'h014, 1, 32'h1234_5678, 0);
    chk(h == 1 && d == 32'h1234_5678, "R3 write hit", d, 32'h1234_5678);
    chk(sf == 0 && sw == 0, "R3 no backend", {sf, sw}, 0);
    acc(12'h014, 0, 0, 0);
    chk(d == 32'h1234_5678, "R3 data kept", d, 32'h1234_5678);
    // general ptr at way1 (dirty 014)
    do_acc(12'h01C, 0, 0, 0, 0, 2, h, d, lat, sw, wba, wbd, sf, fa, wf);
    chk(sw == 1 && wba == 12'h014, "R9 wb addr", wba, 12'h014);
    chk(wbd == 32'h1234_5678, "R9 wb data", wbd, 32'h1234_5678);
    chk(wf == 1 && fa == 12'h01C, "R9 wb before fill", wf, 1);
    chk(d == memv(12'h01C), "R4 data after wb", d, memv(12'h01C));
  endtask

  task automatic t_write_miss();
    acc(12'h02A, 1, 32'h0BAD_F00D, 1);  // set 2
    chk(h == 0 && sf == 1, "R4 write miss fills", h, 0);
    chk(d == 32'h0BAD_F00D, "R4 write miss data", d, 32'h0BAD_F00D);
    acc(12'h02A, 0, 0, 1);
    chk(h == 1 && d == 32'h0BAD_F00D, "R4 installed wdata", d, 32'h0BAD_F00D);
    acc(12'h03A, 0, 0, 1);  // protected way0 of set 2 dirty
    chk(sw == 1 && wba == 12'h02A && wbd == 32'h0BAD_F00D, "R9 crit dirty wb", wba, 12'h02A);
    chk(lat == 5, "R9 wb latency", lat, 5);
  endtask

  task automatic t_backpressure();
    do_acc(12'h03A, 0, 0, 1, 3, 0, h, d, lat, sw, wba, wbd, sf, fa, wf);
    chk(h == 1 && d == memv(12'h03A), "R10 held response", d, memv(12'h03A));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_miss_then_hit();
    t_cross_hit();
    t_thr_evict();
    t_crit_evict();
    t_dirty_wb();
    t_write_miss();
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule